// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a virtual address into a physical address by walking a two-level page table stored in a word-addressed memory. A caller presents a virtual address together with the base of the first-level table. The walker reads one entry from each table level, strictly in order, through a single read port. That port uses a request/acknowledge handshake, so the memory may take any number of cycles to answer.

The first-level entry gives the base of a second-level table. The second-level entry gives the physical page number. The walker joins that page number to the untouched page offset. If either entry is marked absent, the walk stops and a fault is reported instead of a translation.

The block serves one walk at a time. While a walk is running, `busy_o` is high and no new request is taken. Each walk ends with a single-cycle pulse on either `done_o` or `fault_o`. The reset input is asynchronous and active low, and it must be released synchronously to `clk` by the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.
- R2: The virtual address is split as follows: bits [7:5] are the first-level index, bits [4:3] are the second-level index, and bits [2:0] are the page offset. The first memory read is at address (table base + first-level index) modulo 128.
- R3: A table entry is valid when bit 7 is set. In a valid first-level entry, bits [6:0] give the base of the second-level table. The second read is at address (that base + second-level index) modulo 128.
- R4: When both entries are valid, `pa_o` equals {second-level entry bits [4:0], page offset} and `done_o` pulses for exactly one cycle.
- R5: A first-level entry with bit 7 clear produces a one-cycle `fault_o` pulse, and no second memory read is issued.
- R6: A second-level entry with bit 7 clear produces a one-cycle `fault_o` pulse after two reads.
- R7: Each read is a one-cycle pulse on `mem_req_o`. The next read is issued only after `mem_ack_i` has returned the previous entry. Any acknowledge latency of one cycle or more is handled.
- R8: A request is accepted only while the walker is idle. If `req_valid_i` is held high during a walk, it neither changes that walk's memory reads nor changes its result.
- R9: `busy_o` is high from the cycle after a request is accepted through the cycle of the result pulse, and it is low in the cycle that follows.
- R10: The table base is captured when the request is accepted. Changes on `tbl_base_i` during a walk have no effect on that walk.
- R11: `done_o` and `fault_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base_i | input | 7 | Word address of the first-level table |
| req_valid_i | input | 1 | Translation request, sampled when idle |
| req_va_i | input | 8 | Virtual address to translate |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation valid |
| fault_o | output | 1 | One-cycle pulse: unmapped page |
| pa_o | output | 8 | Physical address, valid with `done_o` |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 7 | Read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Table entry read |

## Verification
Directed walks cover each of the three outcomes on their own: an absent first-level entry, an absent second-level entry, and a full translation. They also include a table base near the top of memory, which checks that address sums wrap modulo 128. Random walks run over a randomly filled memory with acknowledge latencies from one to five cycles. In every walk the read addresses and the number of reads are compared against a reference computed in the bench, which tells a correct index split apart from a swapped or shifted one. Some walks hold `req_valid_i` high or toggle the table base mid-walk, to show that neither disturbs a walk already in progress.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    IDLE    = 3'd0,
    RD_L1   = 3'd1,
    WAIT_L1 = 3'd2,
    RD_L2   = 3'd3,
    WAIT_L2 = 3'd4,
    DONE    = 3'd5
  } walk_state_e;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int L1_W  = 3,
  parameter int L2_W  = 2,
  parameter int OFF_W = 3,
  localparam int VA_W = L1_W + L2_W + OFF_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [L1_W-1:0]  idx1_o,
  output logic [L2_W-1:0]  idx2_o,
  output logic [OFF_W-1:0] off_o
);

  // Upper field indexes the root table, middle field the leaf table.
  assign idx1_o = va_i[VA_W-1 -: L1_W];
  assign idx2_o = va_i[OFF_W +: L2_W];
  assign off_o  = va_i[OFF_W-1:0];

endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int ENT_W = 8,
  parameter int MA_W  = 7,
  parameter int PPN_W = 5
) (
  input  logic [ENT_W-1:0] ent_i,
  output logic             valid_o,
  output logic [MA_W-1:0]  ptr_o,
  output logic [PPN_W-1:0] ppn_o
);

  assign valid_o = ent_i[ENT_W-1];
  assign ptr_o   = ent_i[MA_W-1:0];
  assign ppn_o   = ent_i[PPN_W-1:0];

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int MA_W = 7,
  parameter int L1_W = 3,
  parameter int L2_W = 2
) (
  input  logic            sel_l2_i,
  input  logic [MA_W-1:0] root_base_i,
  input  logic [MA_W-1:0] leaf_base_i,
  input  logic [L1_W-1:0] idx1_i,
  input  logic [L2_W-1:0] idx2_i,
  output logic [MA_W-1:0] addr_o
);

  logic [MA_W-1:0] base_sel;
  logic [MA_W-1:0] idx_sel;

  always_comb begin
    if (sel_l2_i) begin
      base_sel = leaf_base_i;
      idx_sel  = MA_W'(idx2_i);
    end else begin
      base_sel = root_base_i;
      idx_sel  = MA_W'(idx1_i);
    end
  end

  // Sum wraps at the memory size.
  assign addr_o = base_sel + idx_sel;

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 8,
  parameter int MA_W  = 7,
  parameter int PPN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [MA_W-1:0]  tbl_base_i,
  input  logic             mem_ack_i,
  input  logic             ent_valid_i,
  input  logic [MA_W-1:0]  ent_ptr_i,
  input  logic [PPN_W-1:0] ent_ppn_i,
  output logic [VA_W-1:0]  va_q_o,
  output logic [MA_W-1:0]  root_base_o,
  output logic [MA_W-1:0]  leaf_base_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             sel_l2_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             mem_req_o
);

  walk_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [MA_W-1:0]  root_q, leaf_q, leaf_d;
  logic [PPN_W-1:0] ppn_q, ppn_d;
  logic             fault_q, fault_d;
  logic             accept;
  logic             leaf_en, ppn_en;

  assign accept = (state_q == IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    leaf_d  = leaf_q;
    ppn_d   = ppn_q;
    fault_d = fault_q;
    leaf_en = 1'b0;
    ppn_en  = 1'b0;
    unique case (state_q)
      IDLE: begin
        if (req_valid_i) begin
          state_d = RD_L1;
          fault_d = 1'b0;
          ppn_d   = '0;
          ppn_en  = 1'b1;
        end
      end
      RD_L1: state_d = WAIT_L1;
      WAIT_L1: begin
        if (mem_ack_i) begin
          if (ent_valid_i) begin
            leaf_d  = ent_ptr_i;
            leaf_en = 1'b1;
            state_d = RD_L2;
          end else begin
            fault_d = 1'b1;
            state_d = DONE;
          end
        end
      end
      RD_L2: state_d = WAIT_L2;
      WAIT_L2: begin
        if (mem_ack_i) begin
          if (ent_valid_i) begin
            ppn_d  = ent_ppn_i;
            ppn_en = 1'b1;
          end else begin
            fault_d = 1'b1;
          end
          state_d = DONE;
        end
      end
      DONE:    state_d = IDLE;
      default: state_d = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
      leaf_q <= '0;
      ppn_q  <= '0;
    end else begin
      if (accept) begin
        va_q   <= req_va_i;
        root_q <= tbl_base_i;
      end
      if (leaf_en) leaf_q <= leaf_d;
      if (ppn_en)  ppn_q  <= ppn_d;
    end
  end

  assign va_q_o      = va_q;
  assign root_base_o = root_q;
  assign leaf_base_o = leaf_q;
  assign ppn_o       = ppn_q;
  assign sel_l2_o    = (state_q == RD_L2);
  assign busy_o      = (state_q != IDLE);
  assign done_o      = (state_q == DONE) && !fault_q;
  assign fault_o     = (state_q == DONE) && fault_q;
  assign mem_req_o   = (state_q == RD_L1) || (state_q == RD_L2);

  AST_NO_DUAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o)); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o); // R7
  AST_REQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o); // R7
  AST_RESULT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |=> !busy_o); // R9
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i) |=> (busy_o && mem_req_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(done_o || fault_o || mem_req_o)); // R1

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int L1_W  = 3,
  parameter int L2_W  = 2,
  parameter int OFF_W = 3,
  parameter int PPN_W = 5,
  parameter int MA_W  = 7,
  parameter int ENT_W = 8,
  localparam int VA_W = L1_W + L2_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MA_W-1:0]  tbl_base_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             mem_req_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [ENT_W-1:0] mem_rdata_i
);

  logic             ent_valid;
  logic [MA_W-1:0]  ent_ptr;
  logic [PPN_W-1:0] ent_ppn;
  logic [VA_W-1:0]  va_q;
  logic [MA_W-1:0]  root_base, leaf_base;
  logic [PPN_W-1:0] ppn;
  logic             sel_l2;
  logic [L1_W-1:0]  idx1;
  logic [L2_W-1:0]  idx2;
  logic [OFF_W-1:0] off;

  pt_entry_dec #(.ENT_W(ENT_W), .MA_W(MA_W), .PPN_W(PPN_W)) u_dec (
    .ent_i   (mem_rdata_i),
    .valid_o (ent_valid),
    .ptr_o   (ent_ptr),
    .ppn_o   (ent_ppn)
  );

  pt_walk_ctrl #(.VA_W(VA_W), .MA_W(MA_W), .PPN_W(PPN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_va_i    (req_va_i),
    .tbl_base_i  (tbl_base_i),
    .mem_ack_i   (mem_ack_i),
    .ent_valid_i (ent_valid),
    .ent_ptr_i   (ent_ptr),
    .ent_ppn_i   (ent_ppn),
    .va_q_o      (va_q),
    .root_base_o (root_base),
    .leaf_base_o (leaf_base),
    .ppn_o       (ppn),
    .sel_l2_o    (sel_l2),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .mem_req_o   (mem_req_o)
  );

  pt_va_split #(.L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_split (
    .va_i   (va_q),
    .idx1_o (idx1),
    .idx2_o (idx2),
    .off_o  (off)
  );

  pt_addr_gen #(.MA_W(MA_W), .L1_W(L1_W), .L2_W(L2_W)) u_agen (
    .sel_l2_i    (sel_l2),
    .root_base_i (root_base),
    .leaf_base_i (leaf_base),
    .idx1_i      (idx1),
    .idx2_i      (idx2),
    .addr_o      (mem_addr_o)
  );

  assign pa_o = {ppn, off};

  AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pa_o[OFF_W-1:0] == va_q[OFF_W-1:0])); // R4

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] tbl_base;
  logic       req_valid;
  logic [7:0] req_va;
  logic       busy, done, fault;
  logic [7:0] pa;
  logic       mem_req;
  logic [6:0] mem_addr;
  logic       mem_ack;
  logic [7:0] mem_rdata;

  logic [7:0] mem [0:127];
  int         mem_lat;
  int         rec_n;
  logic [6:0] rec_addr [0:3];

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base),
    .req_valid_i(req_valid), .req_va_i(req_va),
    .busy_o(busy), .done_o(done), .fault_o(fault), .pa_o(pa),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // Memory responder, acting on falling edges.
  initial begin
    int         cnt;
    logic [6:0] paddr;
    cnt = 0; paddr = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (cnt > 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = mem[paddr];
        end
      end
      if (mem_req) begin
        paddr = mem_addr;
        cnt   = mem_lat;
        if (rec_n < 4) rec_addr[rec_n] = mem_addr;
        rec_n = rec_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void ref_walk(input logic [6:0] base, input logic [7:0] va,
                                   output bit flt, output logic [7:0] xpa,
                                   output int nrd, output logic [6:0] a1,
                                   output logic [6:0] a2);
    logic [7:0] e1, e2;
    a1  = base + 7'(va[7:5]);
    e1  = mem[a1];
    a2  = '0;
    xpa = '0;
    if (!e1[7]) begin
      flt = 1; nrd = 1;
    end else begin
      a2  = e1[6:0] + 7'(va[4:3]);
      e2  = mem[a2];
      nrd = 2;
      flt = !e2[7];
      if (e2[7]) xpa = {e2[4:0], va[2:0]};
    end
  endfunction

  task automatic walk(input logic [6:0] base, input logic [7:0] va, input int lat,
                      input bit hold_req, input bit flip_base);
    bit         xf;
    logic [7:0] xpa;
    int         xn, cyc;
    logic [6:0] xa1, xa2;
    ref_walk(base, va, xf, xpa, xn, xa1, xa2);
    mem_lat = lat;
    @(negedge clk);
    rec_n     = 0;
    tbl_base  = base;
    req_va    = va;
    req_valid = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
    if (hold_req) req_va = ~va;
    else req_valid = 1'b0;
    if (flip_base) tbl_base = ~base;
    cyc = 0;
    while (!(done || fault) && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(!(done && fault), "R11 exclusive result", int'({done, fault}), 1);
    if (xf) begin
      chk(fault === 1'b1, (xn == 1) ? "R5 root null faults" : "R6 leaf null faults",
          int'(fault), 1);
    end else begin
      chk(done === 1'b1, "R4 done pulse", int'(done), 1);
      chk(pa === xpa, "R4 physical address", int'(pa), int'(xpa));
    end
    chk(busy === 1'b1, "R9 busy in result cycle", int'(busy), 1);
    chk(rec_n == xn, (xn == 1) ? "R5 read count" : "R7 read count", rec_n, xn);
    chk(rec_addr[0] === xa1, flip_base ? "R10 root address" : "R2 root address",
        int'(rec_addr[0]), int'(xa1));
    if (xn == 2 && rec_n >= 2)
      chk(rec_addr[1] === xa2, "R3 leaf address", int'(rec_addr[1]), int'(xa2));
    @(negedge clk);
    chk(!done && !fault, "R4 result one cycle", int'({done, fault}), 0);
    chk(busy === 1'b0, "R9 idle after result", int'(busy), 0);
    chk(rec_n == xn, "R8 no extra walk", rec_n, xn);
  endtask

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5a17));
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; tbl_base = '0;
    mem_lat = 1; rec_n = 0;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk({busy, done, fault, mem_req} === 4'b0, "R1 reset outputs",
        int'({busy, done, fault, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fault, mem_req} === 4'b0, "R1 after release",
        int'({busy, done, fault, mem_req}), 0);

    // R5: root entry absent
    mem[7'h13] = 8'h00;
    walk(7'h10, 8'b011_10_101, 2, 0, 0);
    // R6: leaf entry absent
    mem[7'h13] = 8'h80 | 8'h40;
    mem[7'h42] = 8'h00;
    walk(7'h10, 8'b011_10_000, 1, 0, 0);
    // R4: full translation, offset 7, top page number
    mem[7'h42] = 8'h80 | 8'h1f;
    walk(7'h10, 8'b011_10_111, 3, 0, 0);
    // R2/R3: wraparound of both sums
    mem[7'h05] = 8'h80 | 8'h7f;
    mem[7'h02] = 8'h80 | 8'h0a;
    walk(7'h7e, 8'b111_11_000, 5, 0, 0);
    // R8 and R10: request held high and base flipped mid-walk
    walk(7'h10, 8'b011_10_010, 4, 1, 1);

    // Random phase
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    for (int n = 0; n < 80; n++) begin
      walk(7'($urandom), 8'($urandom), 1 + int'($urandom_range(0, 4)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule